// File: doc/BRIEF.md
# Microcomputer Front Panel Controller

This block is the operator console logic for a small 8-bit computer with a 16-bit address space. The console has a bank of address toggle switches, a set button and a clear button for each bit of a data byte, and six command buttons: Examine, Examine Next, Deposit, Deposit Next, Run/Halt and Step. All buttons arrive already debounced, each press being a pulse one clock wide. The block drives a row of address lamps and a row of data lamps. It also drives a run-enable line to the processor.

While the processor runs, the panel stays off the bus. It only mirrors the processor's address and data onto its lamps. While the processor is halted, the panel owns the bus and issues single memory reads and writes through a request port with valid/ready handshaking. An operator picks a location with Examine, then walks through memory with Examine Next. A byte is corrected one bit at a time with the set and clear buttons and stored with Deposit or Deposit Next. Step lets the processor run until its next instruction-complete strobe and then stops it again.

The memory request port follows valid/ready rules. Once `mem_valid` rises, it stays high, and `mem_addr`, `mem_we` and `mem_wdata` stay unchanged until the cycle in which `mem_ready` is sampled high. That cycle completes the transfer. For a read, the returned byte must be on `mem_rdata` in that same cycle. The memory may hold `mem_ready` low for as many cycles as it needs, and nothing is lost while it does so.

Top module: `fpanel_ctrl`

## Requirements
- R1: While `cpu_run` is 1, `mem_valid` stays 0, `led_addr` equals `cpu_addr` and `led_data` equals `cpu_data`.
- R2: While the processor runs, presses of Examine, Examine Next, Deposit, Deposit Next and of any bit set/clear button are ignored. After the next halt, the lamps show the same panel address and data byte as before the run.
- R3: Examine while halted and idle loads `sw_addr` into the panel address and issues a read there (`mem_we`=0). The byte returned with `mem_ready` replaces the data byte shown on `led_data`.
- R4: Examine Next while halted and idle adds one to the panel address, then issues a read at the new address and loads the returned byte as in R3.
- R5: Deposit while halted and idle issues a write (`mem_we`=1) of the current data byte to the current panel address. Deposit Next first adds one to the address and then writes the byte there. The byte written is the value held before any bit edit made in the press cycle.
- R6: Incrementing the panel address from 16'hFFFF gives 16'h0000.
- R7: While halted and idle, a press on bit i's set button makes bit i 1, and a press on its clear button makes bit i 0. No other bit changes. Set and clear pressed on the same bit in the same cycle leave that bit unchanged. The change shows on `led_data` one cycle after the press.
- R8: While a request is outstanding, `mem_valid`, `mem_addr`, `mem_we` and `mem_wdata` hold until `mem_ready`. Command, bit-edit, Run/Halt and Step presses made during that time are ignored, and no second request is issued for them.
- R9: Step while halted and idle raises `cpu_run` in the following cycle. `cpu_run` then falls in the cycle after the first `cpu_insn_done` strobe. Run/Halt presses during a step are ignored.
- R10: After reset the processor is halted (`cpu_run`=0, `bus_own`=1), and the panel address and data byte are both zero. Run/Halt toggles between running and halted when no request is outstanding.
- R11: When presses coincide, priority runs Step, then Run/Halt, then Examine, Examine Next, Deposit and Deposit Next. Only the highest-priority press takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_addr | input | 16 | Address toggle switches |
| btn_set | input | 8 | Per-bit set presses for the data byte |
| btn_clr | input | 8 | Per-bit clear presses for the data byte |
| btn_exam | input | 1 | Examine press |
| btn_exam_nxt | input | 1 | Examine Next press |
| btn_dep | input | 1 | Deposit press |
| btn_dep_nxt | input | 1 | Deposit Next press |
| btn_runhalt | input | 1 | Run/Halt toggle press |
| btn_step | input | 1 | Single instruction step press |
| cpu_insn_done | input | 1 | Processor instruction-complete strobe |
| cpu_addr | input | 16 | Processor address bus, observed only |
| cpu_data | input | 8 | Processor data bus, observed only |
| cpu_run | output | 1 | Run enable to the processor |
| bus_own | output | 1 | Panel owns the bus (processor halted) |
| mem_valid | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory accepts or completes the request |
| mem_we | output | 1 | Request is a write when 1 |
| mem_addr | output | 16 | Request address; panel address when idle |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid with `mem_ready` |
| led_addr | output | 16 | Address lamps |
| led_data | output | 8 | Data lamps |

## Verification
The command buttons are tried from several starting points. One is a plain Examine. Others are successive Examine Next and Deposit Next walks. Others start from the switch value 16'hFFFF, which shows whether the address wraps or carries out. Bit edits are tried with set alone, clear alone, and set and clear on the same bit at once, which shows whether each bit is handled on its own. Presses made while a slow memory holds off `mem_ready`, and presses made while the processor runs, show whether the panel drops them rather than queueing or replaying them. Coinciding presses show whether the stated priority order is followed.

// File: rtl/fpanel_pkg.sv
package fpanel_pkg;

  typedef enum logic [1:0] {
    RS_HALT = 2'd0,
    RS_RUN  = 2'd1,
    RS_STEP = 2'd2
  } run_state_e;

  typedef enum logic [2:0] {
    OP_NONE    = 3'd0,
    OP_EXAM    = 3'd1,
    OP_EXAM_NX = 3'd2,
    OP_DEP     = 3'd3,
    OP_DEP_NX  = 3'd4
  } panel_op_e;

  function automatic panel_op_e pick_op(input logic exam, input logic exam_nx,
                                        input logic dep, input logic dep_nx);
    if (exam)         return OP_EXAM;
    else if (exam_nx) return OP_EXAM_NX;
    else if (dep)     return OP_DEP;
    else if (dep_nx)  return OP_DEP_NX;
    else              return OP_NONE;
  endfunction

endpackage

// File: rtl/fp_runctl.sv
module fp_runctl
  import fpanel_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic idle_i,
  input  logic runhalt_i,
  input  logic step_i,
  input  logic insn_done_i,
  output logic halted_o,
  output logic cpu_run_o
);
  run_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      RS_HALT: begin
        if (idle_i && step_i)         state_d = RS_STEP;
        else if (idle_i && runhalt_i) state_d = RS_RUN;
      end
      RS_RUN:  if (runhalt_i)   state_d = RS_HALT;
      RS_STEP: if (insn_done_i) state_d = RS_HALT;
      default: state_d = RS_HALT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= RS_HALT;
    else        state_q <= state_d;
  end

  assign halted_o  = (state_q == RS_HALT);
  assign cpu_run_o = (state_q != RS_HALT);
endmodule

// File: rtl/fp_memseq.sv
module fp_memseq
  import fpanel_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept_i,
  input  logic          exam_i,
  input  logic          exam_nx_i,
  input  logic          dep_i,
  input  logic          dep_nx_i,
  input  logic [AW-1:0] sw_addr_i,
  input  logic [DW-1:0] latch_i,
  input  logic          mem_ready_i,
  output logic          mem_valid_o,
  output logic          mem_we_o,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] mem_wdata_o,
  output logic          rd_done_o
);
  localparam logic [AW-1:0] ONE = AW'(1);

  panel_op_e       op;
  logic [AW-1:0]   addr_q;
  logic            valid_q;
  logic            we_q;
  logic [DW-1:0]   wdata_q;

  always_comb begin
    op = OP_NONE;
    if (accept_i && !valid_q) op = pick_op(exam_i, exam_nx_i, dep_i, dep_nx_i);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q  <= '0;
      valid_q <= 1'b0;
      we_q    <= 1'b0;
      wdata_q <= '0;
    end else if (valid_q) begin
      if (mem_ready_i) valid_q <= 1'b0;
    end else begin
      unique case (op)
        OP_EXAM: begin
          addr_q  <= sw_addr_i;
          valid_q <= 1'b1;
          we_q    <= 1'b0;
        end
        OP_EXAM_NX: begin
          addr_q  <= addr_q + ONE;
          valid_q <= 1'b1;
          we_q    <= 1'b0;
        end
        OP_DEP: begin
          valid_q <= 1'b1;
          we_q    <= 1'b1;
          wdata_q <= latch_i;
        end
        OP_DEP_NX: begin
          addr_q  <= addr_q + ONE;
          valid_q <= 1'b1;
          we_q    <= 1'b1;
          wdata_q <= latch_i;
        end
        default: ;
      endcase
    end
  end

  assign mem_valid_o = valid_q;
  assign mem_we_o    = we_q;
  assign addr_o      = addr_q;
  assign mem_wdata_o = wdata_q;
  assign rd_done_o   = valid_q && mem_ready_i && !we_q;
endmodule

// File: rtl/fp_latch.sv
module fp_latch #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          edit_en_i,
  input  logic [DW-1:0] set_i,
  input  logic [DW-1:0] clr_i,
  input  logic          load_i,
  input  logic [DW-1:0] load_data_i,
  output logic [DW-1:0] data_o
);
  logic [DW-1:0] bits_q;

  for (genvar i = 0; i < DW; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n)                                   bits_q[i] <= 1'b0;
      else if (load_i)                              bits_q[i] <= load_data_i[i];
      else if (edit_en_i && set_i[i] && !clr_i[i])  bits_q[i] <= 1'b1;
      else if (edit_en_i && clr_i[i] && !set_i[i])  bits_q[i] <= 1'b0;
    end
  end

  assign data_o = bits_q;
endmodule

// File: rtl/fpanel_ctrl.sv
module fpanel_ctrl
  import fpanel_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] sw_addr,
  input  logic [DW-1:0] btn_set,
  input  logic [DW-1:0] btn_clr,
  input  logic          btn_exam,
  input  logic          btn_exam_nxt,
  input  logic          btn_dep,
  input  logic          btn_dep_nxt,
  input  logic          btn_runhalt,
  input  logic          btn_step,
  input  logic          cpu_insn_done,
  input  logic [AW-1:0] cpu_addr,
  input  logic [DW-1:0] cpu_data,
  output logic          cpu_run,
  output logic          bus_own,
  output logic          mem_valid,
  input  logic          mem_ready,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic [AW-1:0] led_addr,
  output logic [DW-1:0] led_data
);
  logic          halted;
  logic          run_en;
  logic          busy;
  logic          rd_done;
  logic          accept;
  logic          edit_en;
  logic [AW-1:0] panel_addr;
  logic [DW-1:0] latch_val;

  // Step and Run/Halt outrank memory commands in the same cycle.
  assign accept  = halted && !btn_step && !btn_runhalt;
  assign edit_en = halted && !busy;

  fp_runctl u_runctl (
    .clk         (clk),
    .rst_n       (rst_n),
    .idle_i      (!busy),
    .runhalt_i   (btn_runhalt),
    .step_i      (btn_step),
    .insn_done_i (cpu_insn_done),
    .halted_o    (halted),
    .cpu_run_o   (run_en)
  );

  fp_memseq #(.AW(AW), .DW(DW)) u_memseq (
    .clk         (clk),
    .rst_n       (rst_n),
    .accept_i    (accept),
    .exam_i      (btn_exam),
    .exam_nx_i   (btn_exam_nxt),
    .dep_i       (btn_dep),
    .dep_nx_i    (btn_dep_nxt),
    .sw_addr_i   (sw_addr),
    .latch_i     (latch_val),
    .mem_ready_i (mem_ready),
    .mem_valid_o (busy),
    .mem_we_o    (mem_we),
    .addr_o      (panel_addr),
    .mem_wdata_o (mem_wdata),
    .rd_done_o   (rd_done)
  );

  fp_latch #(.DW(DW)) u_latch (
    .clk         (clk),
    .rst_n       (rst_n),
    .edit_en_i   (edit_en),
    .set_i       (btn_set),
    .clr_i       (btn_clr),
    .load_i      (rd_done),
    .load_data_i (mem_rdata),
    .data_o      (latch_val)
  );

  assign cpu_run   = run_en;
  assign bus_own   = halted;
  assign mem_valid = busy;
  assign mem_addr  = panel_addr;
  assign led_addr  = run_en ? cpu_addr : panel_addr;
  assign led_data  = run_en ? cpu_data : latch_val;
endmodule

// File: rtl/fp_chk.sv
module fp_chk #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [DW-1:0] btn_set,
  input logic [DW-1:0] btn_clr,
  input logic          btn_exam,
  input logic          btn_exam_nxt,
  input logic          btn_dep,
  input logic          btn_dep_nxt,
  input logic          btn_runhalt,
  input logic          btn_step,
  input logic          cpu_run,
  input logic          mem_valid,
  input logic          mem_ready,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] mem_wdata,
  input logic [DW-1:0] led_data
);
  logic idle_halt;
  assign idle_halt = !cpu_run && !mem_valid && !btn_step && !btn_runhalt;

  // R1
  no_bus_while_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_run |-> !mem_valid);

  // R8
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=>
      (mem_valid && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  // R9
  step_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_run && !mem_valid && btn_step) |=> cpu_run);

  // R6
  addr_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_halt && btn_exam_nxt && !btn_exam) |=>
      (mem_valid && !mem_we && mem_addr == AW'($past(mem_addr) + AW'(1))));

  // R5
  dep_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_halt && btn_dep && !btn_exam && !btn_exam_nxt) |=>
      (mem_valid && mem_we && mem_addr == $past(mem_addr) && mem_wdata == $past(led_data)));

  // R7
  bit_edit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idle_halt |=>
      (led_data == (($past(led_data) | ($past(btn_set) & ~$past(btn_clr)))
                    & ~($past(btn_clr) & ~$past(btn_set)))));
endmodule

bind fpanel_ctrl fp_chk #(.AW(AW), .DW(DW)) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .btn_set      (btn_set),
  .btn_clr      (btn_clr),
  .btn_exam     (btn_exam),
  .btn_exam_nxt (btn_exam_nxt),
  .btn_dep      (btn_dep),
  .btn_dep_nxt  (btn_dep_nxt),
  .btn_runhalt  (btn_runhalt),
  .btn_step     (btn_step),
  .cpu_run      (cpu_run),
  .mem_valid    (mem_valid),
  .mem_ready    (mem_ready),
  .mem_we       (mem_we),
  .mem_addr     (mem_addr),
  .mem_wdata    (mem_wdata),
  .led_data     (led_data)
);

// File: tb/fpanel_ctrl_tb_top.sv
module fpanel_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  typedef struct packed {
    logic        we;
    logic [15:0] addr;
    logic [7:0]  wdata;
  } req_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] sw_addr = '0;
  logic [7:0]  btn_set = '0, btn_clr = '0;
  logic        btn_exam = 0, btn_exam_nxt = 0, btn_dep = 0, btn_dep_nxt = 0;
  logic        btn_runhalt = 0, btn_step = 0, cpu_insn_done = 0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_data = '0;
  logic        cpu_run, bus_own, mem_valid, mem_we;
  logic        mem_ready = 0;
  logic [15:0] mem_addr, led_addr;
  logic [7:0]  mem_wdata, led_data;
  logic [7:0]  mem_rdata = '0;

  int checks = 0;
  int fails  = 0;
  int lat    = 1;
  int wcnt   = 0;
  int cycles = 0;
  req_t exp_q[$];
  logic [15:0] m_addr = '0;
  logic [7:0]  m_data = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fpanel_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .sw_addr(sw_addr), .btn_set(btn_set), .btn_clr(btn_clr),
    .btn_exam(btn_exam), .btn_exam_nxt(btn_exam_nxt), .btn_dep(btn_dep),
    .btn_dep_nxt(btn_dep_nxt), .btn_runhalt(btn_runhalt), .btn_step(btn_step),
    .cpu_insn_done(cpu_insn_done), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
    .cpu_run(cpu_run), .bus_own(bus_own), .mem_valid(mem_valid), .mem_ready(mem_ready),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .led_addr(led_addr), .led_data(led_data)
  );

  function automatic logic [7:0] rd_fn(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h3C;
  endfunction

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  // Watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      chk(1'b0, "watchdog", cycles, WATCHDOG);
      summary();
    end
  end

  // Memory model and scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && cpu_run && mem_valid) chk(1'b0, "R1 bus driven while running", 1, 0);
    if (mem_ready) begin
      mem_ready <= 1'b0;
      wcnt <= 0;
    end else if (rst_n && mem_valid) begin
      if (wcnt >= lat) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R2/R8 unexpected request", {15'd0, mem_we, mem_addr}, 0);
        end else begin
          req_t e;
          e = exp_q.pop_front();
          chk(mem_we == e.we && mem_addr == e.addr && (!e.we || mem_wdata == e.wdata),
              "R3/R4/R5 request", {7'd0, mem_we, mem_addr, mem_wdata},
              {7'd0, e.we, e.addr, e.wdata});
        end
        mem_rdata <= rd_fn(mem_addr);
        mem_ready <= 1'b1;
      end else begin
        wcnt <= wcnt + 1;
      end
    end
  end

  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_done();
    while (exp_q.size() != 0 || mem_valid || mem_ready) tick();
    tick();
  endtask

  // sel: {exam, exam_nxt, dep, dep_nxt}
  task automatic press(input logic [3:0] sel);
    {btn_exam, btn_exam_nxt, btn_dep, btn_dep_nxt} = sel;
    tick();
    {btn_exam, btn_exam_nxt, btn_dep, btn_dep_nxt} = 4'b0;
  endtask

  task automatic do_exam(input logic [15:0] a);
    sw_addr = a;
    m_addr  = a;
    exp_q.push_back('{we: 1'b0, addr: a, wdata: 8'h00});
    press(4'b1000);
    wait_done();
    m_data = rd_fn(a);
  endtask

  task automatic do_exam_nx();
    m_addr = m_addr + 16'd1;
    exp_q.push_back('{we: 1'b0, addr: m_addr, wdata: 8'h00});
    press(4'b0100);
    wait_done();
    m_data = rd_fn(m_addr);
  endtask

  task automatic do_dep(input logic nxt);
    if (nxt) m_addr = m_addr + 16'd1;
    exp_q.push_back('{we: 1'b1, addr: m_addr, wdata: m_data});
    press(nxt ? 4'b0001 : 4'b0010);
    wait_done();
  endtask

  task automatic edit(input logic [7:0] s, input logic [7:0] c);
    btn_set = s; btn_clr = c;
    tick();
    btn_set = '0; btn_clr = '0;
    m_data = (m_data | (s & ~c)) & ~(c & ~s);
  endtask

  task automatic pulse_runhalt();
    btn_runhalt = 1'b1; tick(); btn_runhalt = 1'b0;
  endtask

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick();
    // R10 reset state
    chk(cpu_run == 0 && bus_own == 1, "R10 reset halted", {cpu_run, bus_own}, 2'b01);
    chk(led_addr == 16'h0000 && led_data == 8'h00, "R10 reset lamps", {led_addr, led_data}, 0);

    // R3 examine
    do_exam(16'h1234);
    chk(led_addr == 16'h1234, "R3 examine address", led_addr, 16'h1234);
    chk(led_data == m_data, "R3 examine data", led_data, m_data);

    // R4 examine next
    do_exam_nx();
    chk(led_addr == 16'h1235 && led_data == m_data, "R4 examine next", {led_addr, led_data}, {m_addr, m_data});

    // R7 bit edits
    edit(8'h04, 8'h00);
    chk(led_data == m_data, "R7 set one bit", led_data, m_data);
    edit(8'h00, 8'h02);
    chk(led_data == m_data, "R7 clear one bit", led_data, m_data);
    edit(8'h31, 8'h30);
    chk(led_data == m_data, "R7 set and clear same bit", led_data, m_data);

    // R5 deposit and deposit next
    do_dep(1'b0);
    chk(led_addr == m_addr, "R5 deposit keeps address", led_addr, m_addr);
    lat = 3;
    do_dep(1'b1);
    chk(led_addr == 16'h1236 && led_data == m_data, "R5 deposit next", {led_addr, led_data}, {m_addr, m_data});

    // R6 wrap on both increment commands
    do_exam(16'hFFFF);
    do_exam_nx();
    chk(led_addr == 16'h0000, "R6 examine next wraps", led_addr, 16'h0000);
    do_exam(16'hFFFF);
    do_dep(1'b1);
    chk(led_addr == 16'h0000, "R6 deposit next wraps", led_addr, 16'h0000);

    // R11 priority among commands: examine beats deposit
    sw_addr = 16'h0042;
    m_addr = 16'h0042;
    exp_q.push_back('{we: 1'b0, addr: 16'h0042, wdata: 8'h00});
    press(4'b1011);
    wait_done();
    m_data = rd_fn(16'h0042);
    chk(led_addr == 16'h0042 && led_data == m_data, "R11 examine outranks deposit", {led_addr, led_data}, {m_addr, m_data});

    // R11 run/halt beats examine; R1 mirror while running
    cpu_addr = 16'hBEEF; cpu_data = 8'hA5;
    sw_addr = 16'h7777;
    btn_runhalt = 1'b1; btn_exam = 1'b1;
    tick();
    btn_runhalt = 1'b0; btn_exam = 1'b0;
    chk(cpu_run == 1 && mem_valid == 0, "R11 run outranks examine", {cpu_run, mem_valid}, 2'b10);
    chk(led_addr == 16'hBEEF && led_data == 8'hA5, "R1 lamps mirror bus", {led_addr, led_data}, 24'hBEEFA5);
    cpu_addr = 16'h0101; cpu_data = 8'h5A;
    tick();
    chk(led_addr == 16'h0101 && led_data == 8'h5A && bus_own == 0, "R1 mirror follows bus", {led_addr, led_data}, 24'h01015A);

    // R2 presses while running are ignored
    press(4'b1111);
    edit(8'hFF, 8'h00);
    m_data = rd_fn(16'h0042);
    tick(3);
    pulse_runhalt();
    tick(2);
    chk(cpu_run == 0, "R10 run/halt toggles back", cpu_run, 0);
    chk(led_addr == 16'h0042 && led_data == m_data, "R2 state untouched by run presses", {led_addr, led_data}, {m_addr, m_data});

    // R8 presses during outstanding request are ignored
    lat = 6;
    sw_addr = 16'h2000;
    m_addr  = 16'h2000;
    exp_q.push_back('{we: 1'b0, addr: 16'h2000, wdata: 8'h00});
    press(4'b1000);
    tick();
    press(4'b0011);
    btn_set = 8'hFF; btn_runhalt = 1'b1; tick(); btn_set = '0; btn_runhalt = 1'b0;
    btn_step = 1'b1; tick(); btn_step = 1'b0;
    wait_done();
    tick(3);
    m_data = rd_fn(16'h2000);
    chk(led_addr == 16'h2000 && led_data == m_data && cpu_run == 0, "R8 presses while busy dropped",
        {cpu_run, led_addr, led_data}, {1'b0, m_addr, m_data});
    lat = 1;

    // R9 single step
    btn_step = 1'b1; tick(); btn_step = 1'b0;
    chk(cpu_run == 1, "R9 step starts run", cpu_run, 1);
    pulse_runhalt();
    tick(2);
    chk(cpu_run == 1, "R9 run/halt ignored during step", cpu_run, 1);
    cpu_insn_done = 1'b1; tick(); cpu_insn_done = 1'b0;
    chk(cpu_run == 0 && bus_own == 1, "R9 halts after one instruction", {cpu_run, bus_own}, 2'b01);

    // R11 step outranks run/halt
    btn_step = 1'b1; btn_runhalt = 1'b1; tick(); btn_step = 1'b0; btn_runhalt = 1'b0;
    cpu_insn_done = 1'b1; tick(); cpu_insn_done = 1'b0;
    chk(cpu_run == 0, "R11 step outranks run/halt", cpu_run, 0);

    tick(2);
    chk(exp_q.size() == 0, "R8 all requests seen", exp_q.size(), 0);
    summary();
  end
endmodule